// File: doc/BRIEF.md
# Parallel I/O Host Register Block

This block is the host-facing register file of a 16-bit parallel digital I/O interface. The host writes control offsets with byte or word accesses. The block keeps the configuration in latched registers and presents it as plain fields to the handshake and DMA sequencing blocks beside it. Offset 0 is a trigger register. Each one written there becomes a single-cycle strobe, and nothing is stored. A word write to the handshake output offset loads the output data and sends a start pulse to the handshake engine.

On the read side, the block returns a live status word, a fixed identification byte and the two bytes of the input data bus. It also holds the terminal-count latch. That latch captures the end-of-block signal of the DMA engine and is one of three interrupt sources. Each source has its own enable and is gated by a global enable. The combined request leaves the block as one level-sensitive line, and that line is held low while the interrupt-number field selects "none".

Top module: `pio_host_regs`

## Requirements
- R1: After a synchronous reset, every latched field, the output data and the terminal-count latch are zero, no strobe is high and `irq_req` is low.
- R2: A write to offset 0 produces a pulse exactly one cycle long in the cycle after the write, for each data bit set to one. Bit 0 drives `act_drive_set`, bit 1 drives `act_periph_rst`, bit 2 drives `act_read_start` and bit 3 drives `act_tc_clear`. Zero bits, and bits 7..4, cause no pulse.
- R3: A write to offset 1 loads the board-control fields from the low data byte. Bit 0 is the attention-interrupt enable, bit 1 the ready-interrupt enable, bit 2 the terminal-count interrupt enable, bit 3 the global enable, bit 4 DMA input, bit 5 DMA output and bit 7 word mode. Bit 6 is not stored.
- R4: The setup register has these fields: bits 1..0 line-low drives, bits 4..2 interrupt number (000 = none), bits 6..5 DMA channel, bits 11..9 settle delay, bits 13..12 low-byte clock source and bits 15..14 high-byte clock source. A word write to offset 2 loads all of them. A byte write to offset 2 loads bits 7..0. A byte write to offset 3 loads bits 15..8 from the data's low byte. Bits 7 and 8 are not stored.
- R5: A word write to offset 4 loads both output bytes. A byte write to offset 4 loads only the low byte. A byte write to offset 5 loads only the high byte, taken from the data's low byte.
- R6: A word write to offset 6 loads the full output word and raises `hs_send` for the one cycle after the write. A byte write to offset 6 changes nothing.
- R7: When `dma_tc` and `dma_active` are both high at a clock edge, the terminal-count latch is set. `dma_tc` alone does nothing. Once set, the latch stays set until a clear-TC write.
- R8: When a terminal count arrives in the same cycle as a clear-TC write, the latch ends that cycle set.
- R9: Each interrupt source is active only when its own enable and the global enable are both set. The ready source needs `xfer_ready` high, the attention source needs `attn_n` low and the terminal-count source needs the latch set. Status bits 5, 6 and 7 report the ready, attention and terminal-count sources, and bit 8 reports their OR.
- R10: `irq_req` is the OR of the three sources, forced low while the interrupt-number field is 000. A write that clears the global enable drops it in the following cycle.
- R11: Status (offset 0) carries these bits: bit 0 `xfer_ready`, bits 2..1 the inverted `sense_n`, bit 3 inverted `attn_n`, bit 4 `pstat_in` XOR `pstat_pol`, bit 9 `dma_active`, bit 11 the terminal-count latch and bit 14 word mode. All other bits not named in R9 are zero.
- R12: A read of offset 2 returns 0x63 in the low byte.
- R13: Reads of offset 4 return `din` (a byte read returns the low byte only). A read of offset 5 returns `din[15:8]` in the low byte. Offsets 1, 3, 6 and 7 read zero. Every byte read returns zero in bits 15..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| wr_word | input | 1 | 1 = 16-bit write, 0 = byte write on bits 7..0 |
| wr_addr | input | 3 | Control offset |
| wr_data | input | 16 | Write data |
| rd_word | input | 1 | 1 = 16-bit read, 0 = byte read |
| rd_addr | input | 3 | Status offset |
| rd_data | output | 16 | Read data (combinational) |
| xfer_ready | input | 1 | Interface idle and ready for a transfer |
| sense_n | input | 2 | Two active-low status lines from the peripheral |
| attn_n | input | 1 | Active-low attention line from the peripheral |
| pstat_in | input | 1 | Peripheral status line |
| pstat_pol | input | 1 | Polarity select for the peripheral status line |
| dma_active | input | 1 | DMA engine is moving data |
| dma_tc | input | 1 | Terminal count from the DMA engine |
| din | input | 16 | Input data bus |
| act_drive_set | output | 1 | Strobe: raise the peripheral control line |
| act_periph_rst | output | 1 | Strobe: reset the peripheral |
| act_read_start | output | 1 | Strobe: start an input handshake |
| act_tc_clear | output | 1 | Strobe: terminal count was cleared |
| hs_send | output | 1 | Strobe: start an output handshake |
| dout | output | 16 | Output data bus |
| word_mode | output | 1 | 16-bit DMA transfers |
| dma_in_en | output | 1 | DMA input enable |
| dma_out_en | output | 1 | DMA output enable |
| line_low | output | 2 | Drive the two control lines low |
| irq_sel | output | 3 | Interrupt number select |
| dma_sel | output | 2 | DMA channel select |
| settle_sel | output | 3 | Data settle delay select |
| clk_src_lo | output | 2 | Low-byte input clock source |
| clk_src_hi | output | 2 | High-byte input clock source |
| irq_req | output | 1 | Interrupt request level |

## Verification
A terminal count from the DMA engine can reach the latch in the same cycle as a clear-TC write. Only a set-wins rule keeps that count from being lost. The bench provokes the collision with a directed write to offset 0 with bit 3 set while `dma_tc` and `dma_active` are high. The random phase repeats it many times, because random clear writes land under random terminal counts. The outcome is judged after the edge from status bit 11 and from the terminal-count interrupt: both must stay set while `act_tc_clear` pulses.

// File: rtl/pio_regs_pkg.sv
package pio_regs_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned WORD_W    = 2 * BYTE_W;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned ACT_N     = 4;
    localparam int unsigned SENSE_N   = 2;
    localparam int unsigned LINE_N    = 2;
    localparam int unsigned IRQ_SEL_W = 3;
    localparam int unsigned DMA_SEL_W = 2;
    localparam int unsigned SETTLE_W  = 3;
    localparam int unsigned CLKSRC_W  = 2;
    localparam int unsigned IRQ_SRC_N = 3;

    localparam logic [BYTE_W-1:0] BOARD_ID = 8'h63;

    // control-side offsets
    typedef enum logic [ADDR_W-1:0] {
        REG_ACTION  = 3'd0,
        REG_BCTRL   = 3'd1,
        REG_SETUP_L = 3'd2,
        REG_SETUP_H = 3'd3,
        REG_DOUT_L  = 3'd4,
        REG_DOUT_H  = 3'd5,
        REG_HS_DOUT = 3'd6,
        REG_UNUSED  = 3'd7
    } reg_ofs_e;

    // status-side offsets
    localparam logic [ADDR_W-1:0] RD_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] RD_ID     = 3'd2;
    localparam logic [ADDR_W-1:0] RD_DIN_L  = 3'd4;
    localparam logic [ADDR_W-1:0] RD_DIN_H  = 3'd5;

    // trigger bit positions
    localparam int unsigned ACT_DRIVE   = 0;
    localparam int unsigned ACT_PRST    = 1;
    localparam int unsigned ACT_RDSTART = 2;
    localparam int unsigned ACT_TCCLR   = 3;

    // interrupt source order inside irq_src vectors
    localparam int unsigned SRC_RDY  = 0;
    localparam int unsigned SRC_ATTN = 1;
    localparam int unsigned SRC_TC   = 2;

    // status word bit positions
    localparam int unsigned ST_READY   = 0;
    localparam int unsigned ST_SENSE   = 1;
    localparam int unsigned ST_ATTN    = 3;
    localparam int unsigned ST_PSTAT   = 4;
    localparam int unsigned ST_IRQ_SRC = 5;
    localparam int unsigned ST_IRQ_ANY = 8;
    localparam int unsigned ST_DMA     = 9;
    localparam int unsigned ST_TC      = 11;
    localparam int unsigned ST_WORD    = 14;

    typedef struct packed {
        logic word_mode;
        logic dma_out_en;
        logic dma_in_en;
        logic gie;
        logic tc_ie;
        logic rdy_ie;
        logic attn_ie;
    } bctrl_t;

    typedef struct packed {
        logic [CLKSRC_W-1:0]  clk_hi;
        logic [CLKSRC_W-1:0]  clk_lo;
        logic [SETTLE_W-1:0]  settle;
        logic [DMA_SEL_W-1:0] dma_sel;
        logic [IRQ_SEL_W-1:0] irq_sel;
        logic [LINE_N-1:0]    line_low;
    } setup_t;

    // b = {data[7], data[5:0]}; bit 6 of the byte is dropped by the caller
    function automatic bctrl_t bctrl_unpack(input logic [6:0] b);
        bctrl_t r;
        r.word_mode  = b[6];
        r.dma_out_en = b[5];
        r.dma_in_en  = b[4];
        r.gie        = b[3];
        r.tc_ie      = b[2];
        r.rdy_ie     = b[1];
        r.attn_ie    = b[0];
        return r;
    endfunction

    function automatic setup_t setup_load_lo(input setup_t s, input logic [6:0] b);
        setup_t r;
        r          = s;
        r.line_low = b[1:0];
        r.irq_sel  = b[4:2];
        r.dma_sel  = b[6:5];
        return r;
    endfunction

    function automatic setup_t setup_load_hi(input setup_t s, input logic [7:1] b);
        setup_t r;
        r        = s;
        r.settle = b[3:1];
        r.clk_lo = b[5:4];
        r.clk_hi = b[7:6];
        return r;
    endfunction

endpackage

// File: rtl/pio_wr_decode.sv
module pio_wr_decode
    import pio_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACT_N-1:0]  act_bits,
    output logic [ACT_N-1:0]  act_now,
    output logic [ACT_N-1:0]  act_pulse,
    output logic              ld_bctrl,
    output logic              ld_setup_lo,
    output logic              ld_setup_hi,
    output logic              ld_dout_lo,
    output logic              ld_dout_hi,
    output logic              hs_pulse
);

    logic hit_action;
    logic hit_hs;

    assign hit_action = wr_en && (wr_addr == REG_ACTION);
    assign hit_hs     = wr_en && wr_word && (wr_addr == REG_HS_DOUT);

    // one trigger lane per action bit: combinational for local use, registered for the pins
    for (genvar g = 0; g < ACT_N; g++) begin : g_act
        assign act_now[g] = hit_action && act_bits[g];
        always_ff @(posedge clk) begin
            if (rst) act_pulse[g] <= 1'b0;
            else     act_pulse[g] <= act_now[g];
        end
    end

    assign ld_bctrl    = wr_en && (wr_addr == REG_BCTRL);
    assign ld_setup_lo = wr_en && (wr_addr == REG_SETUP_L);
    assign ld_setup_hi = wr_en && ((wr_word && wr_addr == REG_SETUP_L) ||
                                   (!wr_word && wr_addr == REG_SETUP_H));
    assign ld_dout_lo  = wr_en && (wr_addr == REG_DOUT_L) || hit_hs;
    assign ld_dout_hi  = wr_en && ((wr_word && wr_addr == REG_DOUT_L) ||
                                   (!wr_word && wr_addr == REG_DOUT_H)) || hit_hs;

    always_ff @(posedge clk) begin
        if (rst) hs_pulse <= 1'b0;
        else     hs_pulse <= hit_hs;
    end

    AST_ACT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (act_pulse != '0) |-> ($past(wr_en) && $past(wr_addr) == REG_ACTION)); // R2

    AST_HS_WORD_ONLY: assert property (@(posedge clk) disable iff (rst)
        hs_pulse |-> ($past(wr_word) && $past(wr_en))); // R6

endmodule

// File: rtl/pio_ctrl_store.sv
module pio_ctrl_store
    import pio_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ld_bctrl,
    input  logic              ld_setup_lo,
    input  logic              ld_setup_hi,
    input  logic              ld_dout_lo,
    input  logic              ld_dout_hi,
    output bctrl_t            bctrl_q,
    output setup_t            setup_q,
    output logic [WORD_W-1:0] dout_q
);

    logic [BYTE_W-1:0] lo_b;
    logic [BYTE_W-1:0] hi_b;
    setup_t            setup_n;
    logic [WORD_W-1:0] dout_n;

    // byte writes carry their data on the low lane, whatever byte they target
    assign lo_b = wr_data[BYTE_W-1:0];
    assign hi_b = wr_word ? wr_data[WORD_W-1:BYTE_W] : lo_b;

    always_comb begin
        setup_n = setup_q;
        if (ld_setup_lo) setup_n = setup_load_lo(setup_n, lo_b[6:0]);
        if (ld_setup_hi) setup_n = setup_load_hi(setup_n, hi_b[7:1]);
        dout_n = dout_q;
        if (ld_dout_lo) dout_n[BYTE_W-1:0]      = lo_b;
        if (ld_dout_hi) dout_n[WORD_W-1:BYTE_W] = hi_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bctrl_q <= '0;
            setup_q <= '0;
            dout_q  <= '0;
        end else begin
            if (ld_bctrl) bctrl_q <= bctrl_unpack({lo_b[7], lo_b[5:0]});
            setup_q <= setup_n;
            dout_q  <= dout_n;
        end
    end

    AST_BCTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_bctrl |=> $stable(bctrl_q)); // R3

    AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ld_setup_lo || ld_setup_hi) |=> $stable(setup_q)); // R4

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ld_dout_lo || ld_dout_hi) |=> $stable(dout_q)); // R5

endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit
    import pio_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tc_clr,
    input  logic                 dma_tc,
    input  logic                 dma_active,
    input  logic                 xfer_ready,
    input  logic                 attn_n,
    input  logic                 gie,
    input  logic                 rdy_ie,
    input  logic                 attn_ie,
    input  logic                 tc_ie,
    input  logic [IRQ_SEL_W-1:0] irq_sel,
    output logic                 tc_latched,
    output logic [IRQ_SRC_N-1:0] irq_src,
    output logic                 irq_any,
    output logic                 irq_req
);

    logic                 tc_hit;
    logic [IRQ_SRC_N-1:0] src_cond;
    logic [IRQ_SRC_N-1:0] src_en;

    assign tc_hit = dma_tc && dma_active;

    // a fresh terminal count outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)         tc_latched <= 1'b0;
        else if (tc_hit) tc_latched <= 1'b1;
        else if (tc_clr) tc_latched <= 1'b0;
    end

    always_comb begin
        src_cond           = '0;
        src_en             = '0;
        src_cond[SRC_RDY]  = xfer_ready;
        src_cond[SRC_ATTN] = !attn_n;
        src_cond[SRC_TC]   = tc_latched;
        src_en[SRC_RDY]    = rdy_ie;
        src_en[SRC_ATTN]   = attn_ie;
        src_en[SRC_TC]     = tc_ie;
    end

    for (genvar g = 0; g < IRQ_SRC_N; g++) begin : g_src
        assign irq_src[g] = gie && src_en[g] && src_cond[g];
    end

    assign irq_any = |irq_src;
    assign irq_req = irq_any && (irq_sel != '0);

    AST_TC_CATCH: assert property (@(posedge clk) disable iff (rst)
        (dma_tc && dma_active) |=> tc_latched); // R8

    AST_TC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tc_latched && !tc_clr) |=> tc_latched); // R7

    AST_SRC_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        (irq_src != '0) |-> gie); // R9

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        $fell(gie) |-> !irq_req); // R10

endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
    import pio_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_word,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic                 xfer_ready,
    input  logic [SENSE_N-1:0]   sense_n,
    input  logic                 attn_n,
    input  logic                 pstat_in,
    input  logic                 pstat_pol,
    input  logic [IRQ_SRC_N-1:0] irq_src,
    input  logic                 irq_any,
    input  logic                 dma_active,
    input  logic                 tc_latched,
    input  logic                 word_mode,
    input  logic [WORD_W-1:0]    din,
    output logic [WORD_W-1:0]    rd_data
);

    logic [WORD_W-1:0] status_w;
    logic [WORD_W-1:0] full_w;

    always_comb begin
        status_w                               = '0;
        status_w[ST_READY]                     = xfer_ready;
        status_w[ST_SENSE +: SENSE_N]          = ~sense_n;
        status_w[ST_ATTN]                      = !attn_n;
        status_w[ST_PSTAT]                     = pstat_in ^ pstat_pol;
        status_w[ST_IRQ_SRC +: IRQ_SRC_N]      = irq_src;
        status_w[ST_IRQ_ANY]                   = irq_any;
        status_w[ST_DMA]                       = dma_active;
        status_w[ST_TC]                        = tc_latched;
        status_w[ST_WORD]                      = word_mode;
    end

    always_comb begin
        case (rd_addr)
            RD_STATUS: full_w = status_w;
            RD_ID:     full_w = {{(WORD_W-BYTE_W){1'b0}}, BOARD_ID};
            RD_DIN_L:  full_w = din;
            RD_DIN_H:  full_w = {{(WORD_W-BYTE_W){1'b0}}, din[WORD_W-1:BYTE_W]};
            default:   full_w = '0;
        endcase
    end

    assign rd_data = rd_word ? full_w : {{(WORD_W-BYTE_W){1'b0}}, full_w[BYTE_W-1:0]};

    AST_ID_CONST: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == RD_ID) |-> (rd_data[BYTE_W-1:0] == BOARD_ID)); // R12

endmodule

// File: rtl/pio_host_regs.sv
module pio_host_regs
    import pio_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_word,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 rd_word,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [WORD_W-1:0]    rd_data,
    input  logic                 xfer_ready,
    input  logic [SENSE_N-1:0]   sense_n,
    input  logic                 attn_n,
    input  logic                 pstat_in,
    input  logic                 pstat_pol,
    input  logic                 dma_active,
    input  logic                 dma_tc,
    input  logic [WORD_W-1:0]    din,
    output logic                 act_drive_set,
    output logic                 act_periph_rst,
    output logic                 act_read_start,
    output logic                 act_tc_clear,
    output logic                 hs_send,
    output logic [WORD_W-1:0]    dout,
    output logic                 word_mode,
    output logic                 dma_in_en,
    output logic                 dma_out_en,
    output logic [LINE_N-1:0]    line_low,
    output logic [IRQ_SEL_W-1:0] irq_sel,
    output logic [DMA_SEL_W-1:0] dma_sel,
    output logic [SETTLE_W-1:0]  settle_sel,
    output logic [CLKSRC_W-1:0]  clk_src_lo,
    output logic [CLKSRC_W-1:0]  clk_src_hi,
    output logic                 irq_req
);

    logic [ACT_N-1:0]     act_now;
    logic [ACT_N-1:0]     act_pulse;
    logic                 ld_bctrl;
    logic                 ld_setup_lo;
    logic                 ld_setup_hi;
    logic                 ld_dout_lo;
    logic                 ld_dout_hi;
    bctrl_t               bctrl_q;
    setup_t               setup_q;
    logic                 tc_latched;
    logic [IRQ_SRC_N-1:0] irq_src;
    logic                 irq_any;

    pio_wr_decode u_dec (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_word     (wr_word),
        .wr_addr     (wr_addr),
        .act_bits    (wr_data[ACT_N-1:0]),
        .act_now     (act_now),
        .act_pulse   (act_pulse),
        .ld_bctrl    (ld_bctrl),
        .ld_setup_lo (ld_setup_lo),
        .ld_setup_hi (ld_setup_hi),
        .ld_dout_lo  (ld_dout_lo),
        .ld_dout_hi  (ld_dout_hi),
        .hs_pulse    (hs_send)
    );

    pio_ctrl_store u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_word     (wr_word),
        .wr_data     (wr_data),
        .ld_bctrl    (ld_bctrl),
        .ld_setup_lo (ld_setup_lo),
        .ld_setup_hi (ld_setup_hi),
        .ld_dout_lo  (ld_dout_lo),
        .ld_dout_hi  (ld_dout_hi),
        .bctrl_q     (bctrl_q),
        .setup_q     (setup_q),
        .dout_q      (dout)
    );

    pio_irq_unit u_irq (
        .clk        (clk),
        .rst        (rst),
        .tc_clr     (act_now[ACT_TCCLR]),
        .dma_tc     (dma_tc),
        .dma_active (dma_active),
        .xfer_ready (xfer_ready),
        .attn_n     (attn_n),
        .gie        (bctrl_q.gie),
        .rdy_ie     (bctrl_q.rdy_ie),
        .attn_ie    (bctrl_q.attn_ie),
        .tc_ie      (bctrl_q.tc_ie),
        .irq_sel    (setup_q.irq_sel),
        .tc_latched (tc_latched),
        .irq_src    (irq_src),
        .irq_any    (irq_any),
        .irq_req    (irq_req)
    );

    pio_rd_mux u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_word    (rd_word),
        .rd_addr    (rd_addr),
        .xfer_ready (xfer_ready),
        .sense_n    (sense_n),
        .attn_n     (attn_n),
        .pstat_in   (pstat_in),
        .pstat_pol  (pstat_pol),
        .irq_src    (irq_src),
        .irq_any    (irq_any),
        .dma_active (dma_active),
        .tc_latched (tc_latched),
        .word_mode  (bctrl_q.word_mode),
        .din        (din),
        .rd_data    (rd_data)
    );

    assign act_drive_set  = act_pulse[ACT_DRIVE];
    assign act_periph_rst = act_pulse[ACT_PRST];
    assign act_read_start = act_pulse[ACT_RDSTART];
    assign act_tc_clear   = act_pulse[ACT_TCCLR];

    assign word_mode  = bctrl_q.word_mode;
    assign dma_in_en  = bctrl_q.dma_in_en;
    assign dma_out_en = bctrl_q.dma_out_en;
    assign line_low   = setup_q.line_low;
    assign irq_sel    = setup_q.irq_sel;
    assign dma_sel    = setup_q.dma_sel;
    assign settle_sel = setup_q.settle;
    assign clk_src_lo = setup_q.clk_lo;
    assign clk_src_hi = setup_q.clk_hi;

endmodule

// File: tb/pio_host_regs_tb_top.sv
module pio_host_regs_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_word = 1'b0, rd_word = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, din = '0;
    logic        xfer_ready = 1'b0, attn_n = 1'b1, pstat_in = 1'b0, pstat_pol = 1'b0;
    logic [1:0]  sense_n = 2'b11;
    logic        dma_active = 1'b0, dma_tc = 1'b0;
    logic [15:0] rd_data, dout;
    logic        act_drive_set, act_periph_rst, act_read_start, act_tc_clear, hs_send;
    logic        word_mode, dma_in_en, dma_out_en, irq_req;
    logic [1:0]  line_low, dma_sel, clk_src_lo, clk_src_hi;
    logic [2:0]  irq_sel, settle_sel;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model of the architectural state
    logic [7:0]  m_bc  = '0;
    logic [15:0] m_su  = '0;
    logic [15:0] m_do  = '0;
    logic        m_tc  = 1'b0;
    logic [3:0]  m_act = '0;
    logic        m_hs  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_host_regs dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_word(rd_word), .rd_addr(rd_addr), .rd_data(rd_data),
        .xfer_ready(xfer_ready), .sense_n(sense_n), .attn_n(attn_n),
        .pstat_in(pstat_in), .pstat_pol(pstat_pol), .dma_active(dma_active),
        .dma_tc(dma_tc), .din(din), .act_drive_set(act_drive_set),
        .act_periph_rst(act_periph_rst), .act_read_start(act_read_start),
        .act_tc_clear(act_tc_clear), .hs_send(hs_send), .dout(dout),
        .word_mode(word_mode), .dma_in_en(dma_in_en), .dma_out_en(dma_out_en),
        .line_low(line_low), .irq_sel(irq_sel), .dma_sel(dma_sel),
        .settle_sel(settle_sel), .clk_src_lo(clk_src_lo), .clk_src_hi(clk_src_hi),
        .irq_req(irq_req)
    );

    function automatic logic [2:0] exp_src();
        logic [2:0] s;
        s[0] = m_bc[3] & m_bc[1] & xfer_ready;
        s[1] = m_bc[3] & m_bc[0] & ~attn_n;
        s[2] = m_bc[3] & m_bc[2] & m_tc;
        return s;
    endfunction

    function automatic logic exp_req();
        return (|exp_src()) && (m_su[4:2] != 3'b000);
    endfunction

    function automatic logic [15:0] exp_status();
        logic [15:0] s;
        s       = '0;
        s[0]    = xfer_ready;
        s[2:1]  = ~sense_n;
        s[3]    = ~attn_n;
        s[4]    = pstat_in ^ pstat_pol;
        s[7:5]  = exp_src();
        s[8]    = |exp_src();
        s[9]    = dma_active;
        s[11]   = m_tc;
        s[14]   = m_bc[7];
        return s;
    endfunction

    function automatic logic [15:0] exp_read(input logic [2:0] a, input logic w);
        logic [15:0] v;
        case (a)
            3'd0:    v = exp_status();
            3'd2:    v = 16'h0063;
            3'd4:    v = din;
            3'd5:    v = {8'h00, din[15:8]};
            default: v = '0;
        endcase
        if (!w) v[15:8] = '0;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
        end
    endtask

    // called just after a falling edge; uses under half a period
    task automatic check_all(input string tc_tag);
        chk("R2", {12'h0, act_tc_clear, act_read_start, act_periph_rst, act_drive_set}, {12'h0, m_act});
        chk("R3", {13'h0, word_mode, dma_out_en, dma_in_en}, {13'h0, m_bc[7], m_bc[5], m_bc[4]});
        chk("R4", {2'b0, clk_src_hi, clk_src_lo, settle_sel, dma_sel, irq_sel, line_low},
                  {2'b0, m_su[15:9], m_su[6:0]});
        chk("R5", dout, m_do);
        chk("R6", {15'h0, hs_send}, {15'h0, m_hs});
        chk("R10", {15'h0, irq_req}, {15'h0, exp_req()});
        rd_addr = 3'd0; rd_word = 1'b1; #1;
        chk("R9", {12'h0, rd_data[8:5]}, {12'h0, exp_status() & 16'h01E0} >> 5);
        chk(tc_tag, {15'h0, rd_data[11]}, {15'h0, m_tc});
        for (int a = 0; a < 8; a++) begin
            rd_addr = a[2:0];
            rd_word = 1'($urandom % 2);
            #1;
            if (a == 0)      chk("R11", rd_data, exp_read(rd_addr, rd_word));
            else if (a == 2) chk("R12", rd_data, exp_read(rd_addr, rd_word));
            else             chk("R13", rd_data, exp_read(rd_addr, rd_word));
        end
    endtask

    // drive one cycle (called shortly before a rising edge), advance the model
    task automatic apply(input logic we, input logic ww, input logic [2:0] wa, input logic [15:0] wd);
        logic [3:0]  act_n;
        logic        hs_n;
        logic [7:0]  bc_n;
        logic [15:0] su_n, do_n;
        logic        tc_n;
        wr_en = we; wr_word = ww; wr_addr = wa; wr_data = wd;
        bc_n = m_bc; su_n = m_su; do_n = m_do; tc_n = m_tc;
        act_n = (we && wa == 3'd0) ? wd[3:0] : 4'h0;
        hs_n  = we && ww && (wa == 3'd6);
        if (we) begin
            case (wa)
                3'd1: bc_n = {wd[7], 1'b0, wd[5:0]};
                3'd2: begin
                    su_n[7:0] = {1'b0, wd[6:0]};
                    if (ww) su_n[15:8] = {wd[15:9], 1'b0};
                end
                3'd3: if (!ww) su_n[15:8] = {wd[7:1], 1'b0};
                3'd4: begin
                    do_n[7:0] = wd[7:0];
                    if (ww) do_n[15:8] = wd[15:8];
                end
                3'd5: if (!ww) do_n[15:8] = wd[7:0];
                3'd6: if (ww) do_n = wd;
                default: ;
            endcase
        end
        if (dma_tc && dma_active) tc_n = 1'b1;
        else if (act_n[3])        tc_n = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        m_bc = bc_n; m_su = su_n; m_do = do_n; m_tc = tc_n; m_act = act_n; m_hs = hs_n;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", {15'h0, irq_req}, 16'h0);
        chk("R1", dout, 16'h0);
        check_all("R1");

        // R3 bit 6 dropped; all enables on; R4 word write sets interrupt number 1
        apply(1, 0, 3'd1, 16'h00CF); check_all("R7");
        apply(1, 1, 3'd2, 16'hA604); check_all("R7");
        // R7: terminal count without DMA active is ignored
        dma_tc = 1'b1; apply(0, 0, 3'd0, 16'h0); check_all("R7");
        // R7: captured while active
        dma_active = 1'b1; apply(0, 0, 3'd0, 16'h0); check_all("R7");
        // R8: clear write collides with a new count
        apply(1, 0, 3'd0, 16'h0008); check_all("R8");
        dma_tc = 1'b0; apply(0, 0, 3'd0, 16'h0); check_all("R7");
        // R7: clear alone empties the latch
        apply(1, 0, 3'd0, 16'h0008); check_all("R7");
        // R10: re-latch, then drop global enable
        dma_tc = 1'b1; apply(0, 0, 3'd0, 16'h0); dma_tc = 1'b0; check_all("R7");
        chk("R10", {15'h0, irq_req}, 16'h1);
        apply(1, 0, 3'd1, 16'h0007); check_all("R7");
        chk("R10", {15'h0, irq_req}, 16'h0);
        // R10: enables back on, interrupt number none
        apply(1, 0, 3'd1, 16'h000F); check_all("R7");
        apply(1, 0, 3'd2, 16'h0000); check_all("R7");
        chk("R10", {15'h0, irq_req}, 16'h0);
        // R2: zero bits and upper bits give no pulse
        apply(1, 0, 3'd0, 16'h00F0); check_all("R7");
        apply(1, 0, 3'd0, 16'h0005); check_all("R7");
        // R5, R6: byte lanes and handshake load
        apply(1, 1, 3'd4, 16'h1234); check_all("R7");
        apply(1, 0, 3'd5, 16'h00AB); check_all("R7");
        apply(1, 0, 3'd6, 16'h00EE); check_all("R7");
        apply(1, 1, 3'd6, 16'hBEEF); check_all("R7");
        apply(1, 0, 3'd3, 16'h00FF); check_all("R7");

        for (int i = 0; i < N_RANDOM; i++) begin
            xfer_ready = 1'($urandom % 2);
            sense_n    = 2'($urandom % 4);
            attn_n     = 1'($urandom % 2);
            pstat_in   = 1'($urandom % 2);
            pstat_pol  = 1'($urandom % 2);
            dma_active = 1'($urandom % 2);
            dma_tc     = ($urandom % 4) == 0;
            din        = 16'($urandom);
            apply(($urandom % 4) != 0, 1'($urandom % 2), 3'($urandom % 8), 16'($urandom));
            check_all("R7");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule